// File: doc/BRIEF.md
# Request Burst Protocol Monitor

This block sits passively beside one request port of a memory-side interface and watches its valid/ready handshake, its start and end markers, and the header fields that travel with each request: a 9-bit tag, a 6-bit command, a 3-bit cube identifier and a 34-bit address. The payload bus itself is not observed. A write moves at most two 64-byte beats. Two sideband inputs give the command class of the request: whether it carries a write payload, and how many payload bytes it has. From these the monitor works out how many beats the request must last.

Each rule break raises its own one-cycle pulse on `err_pulse`. The pulse appears in the cycle after the clock edge at which the offending inputs were present. Every pulse is also kept in a matching bit of `err_sticky` until reset. A beat counter reports how many beats of the open request have been accepted. The monitor never drives the port it watches. It is intended for simulation-time and silicon-debug checking of an application that feeds a request port.

Top module: `burst_proto_monitor`

## Requirements
- R1: Holding `rst_n` low across a rising edge of `clk` clears `err_pulse`, `err_sticky` and `beat_cnt` to zero, and closes any open burst.
- R2: A beat is accepted at an edge where `req_valid` and `req_ready` are both 1. `beat_cnt` counts the accepted beats of a request whose end marker has not yet been seen. It saturates at 3 and returns to 0 after the beat that carries `req_eop`. Back-to-back requests with valid held high are legal and raise no pulse.
- R3: Bit 0 of `err_pulse` fires when a beat is accepted outside an open burst and `req_sop` is 0.
- R4: Bit 1 fires when a beat is accepted inside an open burst and `req_sop` is 1.
- R5: Bit 2 fires when a beat is accepted inside an open burst that already holds 2 or more beats.
- R6: Bit 3 fires when a beat is accepted inside an open burst and any of tag, command, cube or address differs from its value on the first beat.
- R7: Bit 4 fires for every edge inside an open burst at which `req_valid` is 0.
- R8: Bit 5 fires for every edge inside an open burst at which `req_ready` is 0.
- R9: Bit 6 fires when an accepted beat's `req_eop` disagrees with whether that beat is the expected last one. The expected beat count is ceil(`req_len`/64) with a minimum of 1 for a write (`req_is_write`=1), and 1 for anything else. It is fixed by the first beat of the request.
- R10: Each bit of `err_sticky` is the OR of every past pulse on the same bit of `err_pulse` since reset, and it stays high until reset.
- R11: Pulses appear exactly one cycle after the offending edge and last one cycle. Cycles with `req_valid` low outside a burst raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the watched port |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester has a beat on the bus |
| req_ready | input | 1 | Receiver can take a beat |
| req_sop | input | 1 | First-beat marker |
| req_eop | input | 1 | Last-beat marker |
| req_tag | input | 9 | Request tag |
| req_cmd | input | 6 | Request command |
| req_cube | input | 3 | Target cube identifier |
| req_addr | input | 34 | Target address |
| req_is_write | input | 1 | Sideband: request carries a write payload |
| req_len | input | 8 | Sideband: payload length in bytes |
| err_pulse | output | 7 | One-cycle event flags, bit map as in R3 to R9 |
| err_sticky | output | 7 | Accumulated event flags |
| beat_cnt | output | 2 | Accepted beats of the open request |

## Verification
A wrong burst-open state or a lost header capture cannot hide for long. At the very next accepted beat it produces either a spurious start-marker pulse (bit 0 or bit 1) or a missed field-change pulse, and the misplaced beat count shows on `beat_cnt` in the same cycle. A stale expected-length register shows up one cycle after the second beat as a wrong end-marker pulse. A sticky bit that clears too early is caught by the per-cycle comparison of `err_sticky` against the bench's accumulated model.

// File: rtl/burst_mon_pkg.sv
// Package: shared field widths, event bit indices and the captured header type
// for the request burst monitor. Assumes a fixed request header layout.
package burst_mon_pkg;
    localparam int TAG_W  = 9;
    localparam int CMD_W  = 6;
    localparam int CUBE_W = 3;
    localparam int ADDR_W = 34;

    // Event bit positions in err_pulse / err_sticky
    localparam int EV_NO_SOP     = 0;
    localparam int EV_SOP_MID    = 1;
    localparam int EV_OVERRUN    = 2;
    localparam int EV_FIELD      = 3;
    localparam int EV_VALID_DROP = 4;
    localparam int EV_READY_DROP = 5;
    localparam int EV_EOP_POS    = 6;
    localparam int EV_N          = 7;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [CMD_W-1:0]  cmd;
        logic [CUBE_W-1:0] cube;
        logic [ADDR_W-1:0] addr;
    } req_hdr_t;
endpackage

// File: rtl/burst_len_calc.sv
// Expected-beat calculator: turns the sideband payload length into the number
// of beats a request must last. Assumes BEAT_BYTES is a power of two.
// Writes need ceil(len/BEAT_BYTES) beats (at least one); other requests need one.
module burst_len_calc #(
    parameter int LEN_W      = 8,
    parameter int BEAT_BYTES = 64,
    localparam int SH        = $clog2(BEAT_BYTES),
    localparam int EXP_W     = LEN_W - SH + 1
) (
    input  logic             is_write,
    input  logic [LEN_W-1:0] len,
    output logic [EXP_W-1:0] exp_beats
);
    logic             tail;
    logic [EXP_W-1:0] rounded;

    // Round the byte count up to whole beats and apply the one-beat floor
    always_comb begin
        tail    = |len[SH-1:0];
        rounded = {1'b0, len[LEN_W-1:SH]} + EXP_W'(tail);
        if (!is_write || rounded == '0)
            exp_beats = EXP_W'(1);
        else
            exp_beats = rounded;
    end
endmodule

// File: rtl/burst_tracker.sv
// Burst tracker: follows the open request across accepted beats, captures the
// header and expected length on the first beat, and raises raw event flags
// for the current edge. Assumes inputs are synchronous to clk.
module burst_tracker
    import burst_mon_pkg::*;
#(
    parameter int MAX_BEATS = 2,
    parameter int EXP_W     = 3,
    localparam int CNT_W    = $clog2(MAX_BEATS + 2),
    localparam int CNT_SAT  = MAX_BEATS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             ready,
    input  logic             sop,
    input  logic             eop,
    input  req_hdr_t         hdr,
    input  logic [EXP_W-1:0] exp_new,
    output logic             in_burst,
    output logic [CNT_W-1:0] beat_cnt,
    output logic [EV_N-1:0]  ev
);
    logic             acc;
    req_hdr_t         hdr_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W:0]   beat_num;
    logic [EXP_W-1:0] exp_cur;

    assign acc = valid && ready;

    // Derive the ordinal of the beat at this edge and its expected total
    always_comb begin
        beat_num = in_burst ? ({1'b0, beat_cnt} + 1'b1) : (CNT_W+1)'(1);
        exp_cur  = in_burst ? exp_q : exp_new;
    end

    // Classify the inputs present at this edge into event flags
    always_comb begin
        ev                = '0;
        ev[EV_NO_SOP]     = acc && !in_burst && !sop;
        ev[EV_SOP_MID]    = acc && in_burst && sop;
        ev[EV_OVERRUN]    = acc && in_burst && (32'(beat_cnt) >= MAX_BEATS);
        ev[EV_FIELD]      = acc && in_burst && (hdr != hdr_q);
        ev[EV_VALID_DROP] = in_burst && !valid;
        ev[EV_READY_DROP] = in_burst && !ready;
        ev[EV_EOP_POS]    = acc && (eop != (32'(beat_num) == 32'(exp_cur)));
    end

    // Open, extend and close the burst on accepted beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst <= 1'b0;
            beat_cnt <= '0;
            hdr_q    <= '0;
            exp_q    <= '0;
        end else if (acc) begin
            if (eop) begin
                in_burst <= 1'b0;
                beat_cnt <= '0;
            end else if (!in_burst) begin
                in_burst <= 1'b1;
                beat_cnt <= CNT_W'(1);
                hdr_q    <= hdr;
                exp_q    <= exp_new;
            end else if (32'(beat_cnt) < CNT_SAT) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

    AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eop) |=> (beat_cnt == '0 && !in_burst)); // R2
    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !eop && in_burst && 32'(beat_cnt) < CNT_SAT)
        |=> (beat_cnt == $past(beat_cnt) + 1'b1)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc) |=> $stable(beat_cnt)); // R2
endmodule

// File: rtl/err_collect.sv
// Error collector: registers the raw event flags into one-cycle pulses and
// accumulates them into sticky bits. Assumes events are single-cycle inputs.
module err_collect #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    output logic [N-1:0] pulse,
    output logic [N-1:0] sticky
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Register one event bit as a pulse and fold it into its sticky bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse[i]  <= 1'b0;
                sticky[i] <= 1'b0;
            end else begin
                pulse[i]  <= ev[i];
                sticky[i] <= sticky[i] | ev[i];
            end
        end

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            sticky[i] |=> sticky[i]); // R10
        AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |-> sticky[i]); // R10
    end
endmodule

// File: rtl/burst_proto_monitor.sv
// Request burst protocol monitor (top): passive observer of one request port.
// Combines the expected-length calculator, burst tracker and error collector.
// Assumes all inputs are synchronous to clk; it drives nothing on the port.
module burst_proto_monitor
    import burst_mon_pkg::*;
#(
    parameter int BEAT_BYTES = 64,
    parameter int MAX_BEATS  = 2,
    parameter int LEN_W      = 8,
    localparam int CNT_W     = $clog2(MAX_BEATS + 2),
    localparam int EXP_W     = LEN_W - $clog2(BEAT_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              req_sop,
    input  logic              req_eop,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [CUBE_W-1:0] req_cube,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_write,
    input  logic [LEN_W-1:0]  req_len,
    output logic [EV_N-1:0]   err_pulse,
    output logic [EV_N-1:0]   err_sticky,
    output logic [CNT_W-1:0]  beat_cnt
);
    req_hdr_t         hdr;
    logic [EXP_W-1:0] exp_beats;
    logic [EV_N-1:0]  ev;
    logic             in_burst;

    // Gather the header fields that must stay fixed across a burst
    always_comb begin
        hdr.tag  = req_tag;
        hdr.cmd  = req_cmd;
        hdr.cube = req_cube;
        hdr.addr = req_addr;
    end

    burst_len_calc #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_len (
        .is_write  (req_is_write),
        .len       (req_len),
        .exp_beats (exp_beats)
    );

    burst_tracker #(.MAX_BEATS(MAX_BEATS), .EXP_W(EXP_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (req_valid),
        .ready    (req_ready),
        .sop      (req_sop),
        .eop      (req_eop),
        .hdr      (hdr),
        .exp_new  (exp_beats),
        .in_burst (in_burst),
        .beat_cnt (beat_cnt),
        .ev       (ev)
    );

    err_collect #(.N(EV_N)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .pulse  (err_pulse),
        .sticky (err_sticky)
    );

    AST_VALID_DROP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && !req_valid) |=> err_pulse[EV_VALID_DROP]); // R7
    AST_READY_DROP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && !req_ready) |=> err_pulse[EV_READY_DROP]); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_burst && !req_valid) |=> (err_pulse == '0)); // R11
    AST_FIRST_NEEDS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_burst && req_valid && req_ready && !req_sop) |=> err_pulse[EV_NO_SOP]); // R3
endmodule

// File: tb/burst_proto_monitor_test.sv
// Bench: behavioural reference model updated every cycle and compared with the
// monitor's outputs half a cycle after each rising edge.
`timescale 1ns/1ps
module burst_proto_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready = 1'b0, req_sop = 1'b0, req_eop = 1'b0;
    logic [8:0]  req_tag = '0;
    logic [5:0]  req_cmd = '0;
    logic [2:0]  req_cube = '0;
    logic [33:0] req_addr = '0;
    logic        req_is_write = 1'b0;
    logic [7:0]  req_len = '0;
    logic [6:0]  err_pulse, err_sticky;
    logic [1:0]  beat_cnt;

    int total = 0;
    int bad = 0;

    // reference model state
    bit          m_open = 0;
    int          m_cnt = 0;
    int          m_exp = 0;
    logic [51:0] m_hdr = '0;
    bit [6:0]    m_pulse = '0;
    bit [6:0]    m_sticky = '0;
    string       bit_req [7] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};

    always #4 clk = ~clk;

    burst_proto_monitor uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sop(req_sop), .req_eop(req_eop), .req_tag(req_tag), .req_cmd(req_cmd),
        .req_cube(req_cube), .req_addr(req_addr), .req_is_write(req_is_write),
        .req_len(req_len), .err_pulse(err_pulse), .err_sticky(err_sticky),
        .beat_cnt(beat_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the currently driven inputs
    task automatic model_edge();
        bit [6:0]    ev = '0;
        bit          acc = req_valid && req_ready;
        int          expn;
        int          bn;
        int          ex;
        logic [51:0] h = {req_tag, req_cmd, req_cube, req_addr};
        if (!rst_n) begin
            m_open = 0; m_cnt = 0; m_exp = 0; m_pulse = '0; m_sticky = '0;
            return;
        end
        expn = req_is_write ? (int'(req_len) + 63) / 64 : 1;
        if (expn == 0) expn = 1;
        bn = m_open ? m_cnt + 1 : 1;
        ex = m_open ? m_exp : expn;
        if (acc && !m_open && !req_sop) ev[0] = 1;
        if (acc && m_open && req_sop)   ev[1] = 1;
        if (acc && m_open && m_cnt >= 2) ev[2] = 1;
        if (acc && m_open && h != m_hdr) ev[3] = 1;
        if (m_open && !req_valid) ev[4] = 1;
        if (m_open && !req_ready) ev[5] = 1;
        if (acc && (req_eop != (bn == ex))) ev[6] = 1;
        if (acc) begin
            if (req_eop) begin
                m_open = 0; m_cnt = 0;
            end else if (!m_open) begin
                m_open = 1; m_cnt = 1; m_hdr = h; m_exp = expn;
            end else if (m_cnt < 3) begin
                m_cnt++;
            end
        end
        m_pulse = ev;
        m_sticky |= ev;
    endtask

    // One clock: model steps at the edge, outputs compared at the falling edge
    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(beat_cnt == 2'(m_cnt), {tag, " R2 beat_cnt"}, int'(beat_cnt), m_cnt);
        for (int i = 0; i < 7; i++)
            check(err_pulse[i] == m_pulse[i], {tag, " ", bit_req[i], " pulse"},
                  int'(err_pulse[i]), int'(m_pulse[i]));
        check(err_sticky == 7'(m_sticky), {tag, " R10 sticky"}, int'(err_sticky), int'(m_sticky));
    endtask

    task automatic drive(input bit v, input bit r, input bit s, input bit e,
                         input int tag, input int addr, input bit w, input int len);
        req_valid = v; req_ready = r; req_sop = s; req_eop = e;
        req_tag = 9'(tag); req_cmd = w ? 6'h09 : 6'h31; req_cube = 3'd2;
        req_addr = 34'(addr); req_is_write = w; req_len = 8'(len);
    endtask

    task automatic idle(input string tag);
        drive(0, 1, 0, 0, 0, 0, 0, 0);
        tick(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle("R1 reset");
        rst_n = 1'b1;
        check(err_sticky == '0 && err_pulse == '0 && beat_cnt == '0, "R1 cleared",
              int'(err_sticky), 0);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        repeat (3) idle("R11 idle");

        // R2: legal traffic, back-to-back with valid held
        drive(1, 1, 1, 1, 5, 'h100, 0, 0);   tick("R2 read");
        drive(1, 1, 1, 0, 6, 'h200, 1, 128); tick("R2 wr128 b1");
        drive(1, 1, 0, 1, 6, 'h200, 1, 128); tick("R2 wr128 b2");
        drive(1, 1, 1, 1, 7, 'h300, 1, 64);  tick("R2 wr64");
        drive(1, 1, 1, 0, 8, 'h400, 1, 112); tick("R2 wr112 b1");
        drive(0, 1, 0, 0, 8, 'h400, 1, 112); tick("R7 gap");
        drive(1, 1, 0, 1, 8, 'h400, 1, 112); tick("R2 wr112 b2");
        drive(1, 1, 1, 1, 9, 'h500, 1, 16);  tick("R2 wr16");
        drive(1, 0, 1, 1, 9, 'h500, 1, 16);  tick("R11 stall outside");
        idle("R11 idle");

        // R3: missing start marker
        drive(1, 1, 0, 1, 10, 'h600, 0, 0);  tick("R3 no sop");
        idle("R11 pulse gone");
        do_reset();

        // R4: start marker repeated mid-burst
        drive(1, 1, 1, 0, 11, 'h700, 1, 128); tick("R4 b1");
        drive(1, 1, 1, 1, 11, 'h700, 1, 128); tick("R4 sop mid");
        do_reset();

        // R5 + R9: third beat of a two-beat write
        drive(1, 1, 1, 0, 12, 'h800, 1, 128); tick("R5 b1");
        drive(1, 1, 0, 0, 12, 'h800, 1, 128); tick("R5 b2 no eop");
        drive(1, 1, 0, 1, 12, 'h800, 1, 128); tick("R5 b3");
        do_reset();

        // R6: address changes on second beat; then tag change
        drive(1, 1, 1, 0, 13, 'h900, 1, 100); tick("R6 b1");
        drive(1, 1, 0, 1, 13, 'h910, 1, 100); tick("R6 addr");
        drive(1, 1, 1, 0, 14, 'h920, 1, 100); tick("R6 b1");
        drive(1, 1, 0, 1, 15, 'h920, 1, 100); tick("R6 tag");
        do_reset();

        // R8: receiver drops ready in mid-burst
        drive(1, 1, 1, 0, 16, 'hA00, 1, 65);  tick("R8 b1");
        drive(1, 0, 0, 1, 16, 'hA00, 1, 65);  tick("R8 ready drop");
        drive(1, 0, 0, 1, 16, 'hA00, 1, 65);  tick("R8 ready drop 2");
        drive(1, 1, 0, 1, 16, 'hA00, 1, 65);  tick("R8 b2");
        do_reset();

        // R9: end marker too early, then missing on a one-beat write
        drive(1, 1, 1, 1, 17, 'hB00, 1, 128); tick("R9 early eop");
        drive(1, 1, 1, 0, 18, 'hB10, 1, 0);   tick("R9 missing eop");
        drive(1, 1, 0, 1, 18, 'hB10, 1, 0);   tick("R9 b2");
        idle("R10 sticky holds");
        idle("R10 sticky holds");
        do_reset();
        idle("R1 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule